// File: doc/BRIEF.md
# Byte-Opcode SPI Sequencer

This block is a half-duplex SPI master run by a small program held in a 64-bit sequence register. The program is a list of up to eight one-byte opcodes. Each opcode either picks a chip select, shifts a number of bytes out of a 64-bit transmit word, shifts a number of bytes into a 64-bit receive word, re-arms the transmit word, jumps to another slot, or stops. Software loads transmit words one at a time, starts the program by writing the sequence register, and collects received data from the receive register. The full, overrun and underrun flags on both data registers pace it.

A 64-bit register port reaches five registers, selected by `reg_addr`: clock configuration (3), transmit data (5), receive data (6), sequence (7) and status (8). Writes take effect on the clock edge. A read returns its value on `reg_rdata` one cycle after `reg_rd`. The clock configuration register sets the SCK divider and carries a two-step soft reset.

Top module: `opseq_spi`

## Requirements
- R1: After reset, all `cs_n` lines are high, `sck` and `mosi` are low, and status reads exactly 0x0001_0000_0000_0000 (state field bits 55:48 = 0x01, idle).
- R2: Writing the sequence register while the state is idle starts the program at slot 0, which is bits 63:56. Each later slot is the next lower byte. The sequencer returns to idle on opcode 0x00 or after it executes slot 7.
- R3: Opcode 0x1N with N ≥ 1 drives `cs_n[N-1]` low and all other lines high. 0x10 drives them all high. At most one line is low at any time.
- R4: Opcode 0x3N (N = 1..8) consumes the transmit word and clears transmit-full (status bit 59). It sends the N bytes from bits 63:56 downward, MSB first, in SPI mode 0: `mosi` is set while `sck` is low and is held steady while `sck` is high.
- R5: When a 0x3N finds the transmit word empty, the sequencer sets transmit-underrun (bit 57) and waits in state 0x04. It resumes as soon as a word is written.
- R6: Opcode 0x4N (N = 1..8) receives N bytes right-aligned, with the first byte at bits 8N-1:8N-8. It sets receive-full (bit 63), and reading the receive register clears that flag.
- R7: One SCK period lasts 2·(D+1) clocks, with the high phase lasting D+1 clocks. D is bits 63:52 of the clock configuration register.
- R8: Writing the transmit register while it is full sets transmit-overrun (bit 58) and leaves the stored word unchanged.
- R9: Reading the receive register while it is empty sets receive-underrun (bit 61). A completed shift-in while receive-full is still set sets receive-overrun (bit 62) and keeps the old word.
- R10: Opcode 0xEN (N = 0..7) continues at slot N. Opcode 0xC0 sets transmit-full again, so the next shift-out resends the same word.
- R11: An illegal opcode sets error bit 12, returns the sequencer to idle and deasserts all chip selects. Illegal opcodes are any undefined value, a shift count of 0 or above 8, a branch target above 7, and a shift-in that does not directly follow a shift-out.
- R12: A write to the sequence register while the sequencer is not idle is ignored, and the register reads back its old program.
- R13: Any write to status clears bits 57, 58, 61, 62 and 12. Writing clock configuration with bits 36 and 38 set, and then with bits 37 and 39 set, soft-resets the block: the state goes to idle, all chip selects are deasserted, and the full and sticky flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after `reg_rd` |
| sck | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in, sampled on the rising edge of `sck` |
| cs_n | output | NCS | Active-low chip selects |

## Verification
Programs are run that cover each opcode family alone and in combination: a two-byte send, a send followed by a two-byte receive on a different select, and a 16-byte send split over two words where the second word arrives late. Together these separate byte order, right alignment of received data, chip-select decoding and the stall-and-resume path. Branch, re-arm and a program that runs through all eight slots check the fetch order and where execution ends. Illegal opcodes, double writes, empty reads and a write during a run check each flag against the bit that should fire. Two divider values check the SCK period, and a monitor checks the width of every high phase.

// File: rtl/opseq_pkg.sv
package opseq_pkg;
  typedef enum logic [7:0] {
    ST_IDLE  = 8'h01,
    ST_RUN   = 8'h02,
    ST_WAIT  = 8'h04,
    ST_SHIFT = 8'h08
  } seq_state_t;

  localparam logic [3:0] A_CLKCFG = 4'd3;
  localparam logic [3:0] A_TXD    = 4'd5;
  localparam logic [3:0] A_RXD    = 4'd6;
  localparam logic [3:0] A_PROG   = 4'd7;
  localparam logic [3:0] A_STAT   = 4'd8;

  localparam logic [3:0] OPH_END  = 4'h0;
  localparam logic [3:0] OPH_SEL  = 4'h1;
  localparam logic [3:0] OPH_OUT  = 4'h3;
  localparam logic [3:0] OPH_IN   = 4'h4;
  localparam logic [3:0] OPH_COPY = 4'hC;
  localparam logic [3:0] OPH_JMP  = 4'hE;
endpackage

// File: rtl/opseq_shifter.sv
module opseq_shifter #(
  parameter int DIVW  = 12,
  parameter int WORDW = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIVW-1:0]  div,
  input  logic             start,
  input  logic             dir_in,
  input  logic [3:0]       nbytes,
  input  logic [WORDW-1:0] tx_word,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [WORDW-1:0] rx_word
);
  localparam int CNTW = $clog2(WORDW) + 1;

  logic [DIVW-1:0]  cnt;
  logic [CNTW-1:0]  bits_left;
  logic [WORDW-1:0] sh;
  logic             in_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      bits_left <= '0;
      sh        <= '0;
      in_mode   <= 1'b0;
      sck       <= 1'b0;
      mosi      <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rx_word   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          cnt       <= '0;
          sh        <= tx_word;
          bits_left <= CNTW'({nbytes, 3'b000});
          in_mode   <= dir_in;
          mosi      <= dir_in ? 1'b0 : tx_word[WORDW-1];
          rx_word   <= '0;
        end
      end else if (cnt == div) begin
        cnt <= '0;
        if (!sck) begin
          sck <= 1'b1;
          if (in_mode) rx_word <= {rx_word[WORDW-2:0], miso};
        end else begin
          sck       <= 1'b0;
          sh        <= sh << 1;
          bits_left <= bits_left - 1'b1;
          if (bits_left == CNTW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            mosi <= 1'b0;
          end else begin
            mosi <= in_mode ? 1'b0 : sh[WORDW-2];
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/opseq_engine.sv
module opseq_engine
  import opseq_pkg::*;
#(
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [63:0]    prog,
  input  logic           tx_full,
  input  logic           sh_done,
  output seq_state_t     state,
  output logic [NCS-1:0] cs_n,
  output logic           sh_start,
  output logic           sh_in,
  output logic [3:0]     sh_n,
  output logic           tx_take,
  output logic           tx_copy,
  output logic           rx_store,
  output logic           tx_starve,
  output logic           bad_op
);
  seq_state_t st_n;
  logic [2:0] pc, pc_n;
  logic [3:0] sel, sel_n, nb, nb_n;
  logic       in_m, in_n, last_out, lo_n, adv;
  logic [5:0] base;
  logic [7:0] op;
  logic [3:0] hi, lo;

  always_comb begin
    base = {~pc, 3'b000};
    op   = prog[base +: 8];
    hi   = op[7:4];
    lo   = op[3:0];
  end

  always_comb begin
    st_n = state; pc_n = pc; sel_n = sel; nb_n = nb; in_n = in_m; lo_n = last_out;
    sh_start = 1'b0; tx_take = 1'b0; tx_copy = 1'b0; rx_store = 1'b0;
    tx_starve = 1'b0; bad_op = 1'b0; adv = 1'b0;
    case (state)
      ST_IDLE: if (go) begin st_n = ST_RUN; pc_n = '0; lo_n = 1'b0; end
      ST_RUN: begin
        lo_n = 1'b0;
        case (hi)
          OPH_END: if (lo == 4'd0) st_n = ST_IDLE; else bad_op = 1'b1;
          OPH_SEL: begin sel_n = lo; adv = 1'b1; end
          OPH_OUT: begin
            if (lo == 4'd0 || lo > 4'd8) bad_op = 1'b1;
            else begin
              nb_n = lo; in_n = 1'b0;
              if (tx_full) begin tx_take = 1'b1; sh_start = 1'b1; st_n = ST_SHIFT; end
              else begin tx_starve = 1'b1; st_n = ST_WAIT; end
            end
          end
          OPH_IN: begin
            if (lo == 4'd0 || lo > 4'd8 || !last_out) bad_op = 1'b1;
            else begin nb_n = lo; in_n = 1'b1; sh_start = 1'b1; st_n = ST_SHIFT; end
          end
          OPH_COPY: if (lo == 4'd0) begin tx_copy = 1'b1; adv = 1'b1; end else bad_op = 1'b1;
          OPH_JMP:  if (lo < 4'd8) pc_n = lo[2:0]; else bad_op = 1'b1;
          default:  bad_op = 1'b1;
        endcase
        if (bad_op) begin st_n = ST_IDLE; sel_n = '0; end
      end
      ST_WAIT: if (tx_full) begin tx_take = 1'b1; sh_start = 1'b1; st_n = ST_SHIFT; end
      ST_SHIFT: if (sh_done) begin rx_store = in_m; lo_n = !in_m; adv = 1'b1; end
      default: st_n = ST_IDLE;
    endcase
    if (adv) begin
      if (pc == 3'd7) st_n = ST_IDLE;
      else begin pc_n = pc + 3'd1; st_n = ST_RUN; end
    end
    sh_n  = nb_n;
    sh_in = in_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; pc <= '0; sel <= '0; nb <= '0;
      in_m <= 1'b0; last_out <= 1'b0; cs_n <= '1;
    end else begin
      state <= st_n; pc <= pc_n; sel <= sel_n; nb <= nb_n;
      in_m <= in_n; last_out <= lo_n;
      for (int i = 0; i < NCS; i++) cs_n[i] <= (sel_n != 4'(i + 1));
    end
  end
endmodule

// File: rtl/opseq_spi.sv
module opseq_spi
  import opseq_pkg::*;
#(
  parameter int NCS  = 4,
  parameter int DIVW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [3:0]     reg_addr,
  input  logic [63:0]    reg_wdata,
  output logic [63:0]    reg_rdata,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);
  localparam int WORDW   = 64;
  localparam int DIV_LSB = WORDW - DIVW;
  localparam int ERR_BIT = 12;

  seq_state_t       st;
  logic [DIVW-1:0]  div;
  logic             arm, srst_q, core_rst;
  logic [WORDW-1:0] prog, tx_data, rx_data, sh_rx, status;
  logic             tx_full, rx_full, tx_unr, tx_ovr, rx_unr, rx_ovr, err;
  logic             wr_clk, wr_tx, wr_prog, wr_stat, rd_rx, go;
  logic             sh_start, sh_in, sh_busy, sh_done;
  logic [3:0]       sh_n;
  logic             tx_take, tx_copy, rx_store, tx_starve, bad_op;

  assign core_rst = rst | srst_q;
  assign wr_clk   = reg_wr && reg_addr == A_CLKCFG;
  assign wr_tx    = reg_wr && reg_addr == A_TXD;
  assign wr_prog  = reg_wr && reg_addr == A_PROG;
  assign wr_stat  = reg_wr && reg_addr == A_STAT;
  assign rd_rx    = reg_rd && reg_addr == A_RXD;
  assign go       = wr_prog && st == ST_IDLE;

  opseq_engine #(.NCS(NCS)) u_eng (
    .clk(clk), .rst(core_rst), .go(go), .prog(prog), .tx_full(tx_full),
    .sh_done(sh_done), .state(st), .cs_n(cs_n), .sh_start(sh_start),
    .sh_in(sh_in), .sh_n(sh_n), .tx_take(tx_take), .tx_copy(tx_copy),
    .rx_store(rx_store), .tx_starve(tx_starve), .bad_op(bad_op)
  );

  opseq_shifter #(.DIVW(DIVW), .WORDW(WORDW)) u_shf (
    .clk(clk), .rst(core_rst), .div(div), .start(sh_start), .dir_in(sh_in),
    .nbytes(sh_n), .tx_word(tx_data), .miso(miso), .sck(sck), .mosi(mosi),
    .busy(sh_busy), .done(sh_done), .rx_word(sh_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div <= '0; arm <= 1'b0; srst_q <= 1'b0;
    end else begin
      srst_q <= 1'b0;
      if (wr_clk) begin
        div    <= reg_wdata[WORDW-1 -: DIVW];
        arm    <= reg_wdata[36] && reg_wdata[38];
        srst_q <= arm && reg_wdata[37] && reg_wdata[39];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      prog <= '0; tx_data <= '0; rx_data <= '0;
      tx_full <= 1'b0; rx_full <= 1'b0;
      tx_unr <= 1'b0; tx_ovr <= 1'b0; rx_unr <= 1'b0; rx_ovr <= 1'b0; err <= 1'b0;
    end else begin
      if (wr_stat) begin
        tx_unr <= 1'b0; tx_ovr <= 1'b0; rx_unr <= 1'b0; rx_ovr <= 1'b0; err <= 1'b0;
      end
      if (go) prog <= reg_wdata;
      if (tx_starve) tx_unr <= 1'b1;
      if (bad_op) err <= 1'b1;
      if (tx_take) tx_full <= 1'b0;
      if (tx_copy) tx_full <= 1'b1;
      if (wr_tx) begin
        if (tx_full) tx_ovr <= 1'b1;
        else begin tx_data <= reg_wdata; tx_full <= 1'b1; end
      end
      if (rd_rx) begin
        if (!rx_full) rx_unr <= 1'b1;
        rx_full <= 1'b0;
      end
      if (rx_store) begin
        if (rx_full && !rd_rx) rx_ovr <= 1'b1;
        else begin rx_data <= sh_rx; rx_full <= 1'b1; end
      end
    end
  end

  always_comb begin
    status          = '0;
    status[63]      = rx_full;
    status[62]      = rx_ovr;
    status[61]      = rx_unr;
    status[59]      = tx_full;
    status[58]      = tx_ovr;
    status[57]      = tx_unr;
    status[55:48]   = st;
    status[ERR_BIT] = err;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        A_CLKCFG: reg_rdata <= {div, {DIV_LSB{1'b0}}};
        A_TXD:    reg_rdata <= tx_data;
        A_RXD:    reg_rdata <= rx_data;
        A_PROG:   reg_rdata <= prog;
        A_STAT:   reg_rdata <= status;
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/opseq_spi_chk.sv
module opseq_spi_chk
  import opseq_pkg::*;
#(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           core_rst,
  input logic [NCS-1:0] cs_n,
  input logic           sck,
  input logic           mosi,
  input seq_state_t     st,
  input logic           go,
  input logic           wr_tx,
  input logic           tx_full,
  input logic           tx_ovr,
  input logic           rd_rx,
  input logic           rx_full,
  input logic           rx_unr
);
  // R3: never more than one select active
  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (core_rst)
    $onehot0(~cs_n));
  // R2: a start leaves idle on the next cycle
  p_start_r2: assert property (@(posedge clk) disable iff (core_rst)
    go |=> st != ST_IDLE);
  // R4: data is steady through the high phase of SCK
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (core_rst)
    (sck && $past(sck)) |-> $stable(mosi));
  // R7: SCK stays low whenever the sequencer is idle
  p_sck_idle_r7: assert property (@(posedge clk) disable iff (core_rst)
    st == ST_IDLE |-> !sck);
  // R8: write to a full transmit register flags overrun
  p_tx_ovr_r8: assert property (@(posedge clk) disable iff (core_rst)
    (wr_tx && tx_full) |=> tx_ovr);
  // R9: read of an empty receive register flags underrun
  p_rx_unr_r9: assert property (@(posedge clk) disable iff (core_rst)
    (rd_rx && !rx_full) |=> rx_unr);
endmodule

bind opseq_spi opseq_spi_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .core_rst(core_rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
  .st(st), .go(go), .wr_tx(wr_tx), .tx_full(tx_full), .tx_ovr(tx_ovr),
  .rd_rx(rd_rx), .rx_full(rx_full), .rx_unr(rx_unr)
);

// File: tb/opseq_spi_test.sv
module opseq_spi_test;
  localparam int NCS = 4;
  localparam logic [63:0] IDLE_ST = 64'h0001_0000_0000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic sck, mosi, miso;
  logic [NCS-1:0] cs_n;

  int vectors = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  opseq_spi #(.NCS(NCS), .DIVW(12)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural SPI slave and timing model, sampled between clock edges
  bit        mosi_q[$];
  logic [63:0] miso_pat = '0;
  int        exp_div = 0;
  int        cyc = 0, last_rise = -1, period = 0, hi_cnt = 0;
  logic [NCS-1:0] cs_at_rise = '1;
  logic      prev_sck = 1'b0;
  assign miso = miso_pat[63];

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (sck) hi_cnt++;
      if (sck && !prev_sck) begin
        mosi_q.push_back(mosi);
        cs_at_rise = cs_n;
        if (last_rise >= 0) period = cyc - last_rise;
        last_rise = cyc;
        miso_pat = miso_pat << 1;
      end
      if (!sck && prev_sck) begin
        check("R7 high phase width", 64'(hi_cnt), 64'(exp_div + 1));
        hi_cnt = 0;
      end
      prev_sck = sck;
    end
  end

  function automatic logic [7:0] qbyte(input int i);
    logic [7:0] v = '0;
    for (int b = 0; b < 8; b++) v = {v[6:0], mosi_q[i*8+b]};
    return v;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_state(input logic [7:0] s, input string req);
    logic [63:0] r;
    int n = 0;
    rd(4'd8, r);
    while (r[55:48] !== s && n < 3000) begin rd(4'd8, r); n++; end
    check(req, 64'(r[55:48]), 64'(s));
  endtask

  task automatic start_run(input logic [63:0] p);
    mosi_q.delete();
    last_rise = -1;
    wr(4'd7, p);
  endtask

  initial begin
    logic [63:0] r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 cs_n", 64'(cs_n), 64'hF);
    check("R1 sck/mosi", {62'b0, sck, mosi}, 64'h0);
    rd(4'd8, r); check("R1 status", r, IDLE_ST);

    wr(4'd3, 64'd1 << 52); exp_div = 1;

    // R2 R4: two-byte send on select 1
    wr(4'd5, 64'hA53C_0000_0000_0000);
    start_run({8'h11, 8'h32, 8'h10, 8'h00, 32'h0});
    wait_state(8'h01, "R2 back to idle");
    check("R4 bit count", 64'(mosi_q.size()), 64'd16);
    check("R4 byte0", 64'(qbyte(0)), 64'hA5);
    check("R4 byte1", 64'(qbyte(1)), 64'h3C);
    check("R3 select 1 during shift", 64'(cs_at_rise), 64'hE);
    check("R3 deselect", 64'(cs_n), 64'hF);
    check("R7 period div1", 64'(period), 64'd4);
    rd(4'd8, r); check("R4 tx consumed", r, IDLE_ST);

    // R6: send one byte then receive two on select 2
    wr(4'd5, 64'h5A00_0000_0000_0000);
    start_run({8'h12, 8'h31, 8'h42, 8'h10, 32'h0});
    miso_pat = {8'h00, 16'hBEEF, 40'h0};
    wait_state(8'h01, "R6 idle");
    check("R3 select 2", 64'(cs_at_rise), 64'hD);
    check("R6 sent byte", 64'(qbyte(0)), 64'h5A);
    rd(4'd8, r); check("R6 rx full", r, 64'h8001_0000_0000_0000);
    rd(4'd6, r); check("R6 right aligned", r, 64'h0000_0000_0000_BEEF);
    rd(4'd8, r); check("R6 read clears full", r, IDLE_ST);

    // R5: 16-byte send with late second word
    wr(4'd5, 64'h0102_0304_0506_0708);
    start_run({8'h11, 8'h38, 8'h38, 8'h10, 32'h0});
    wait_state(8'h04, "R5 waits for word");
    wr(4'd5, 64'h1112_1314_1516_1718);
    wait_state(8'h01, "R5 resumes");
    check("R5 bit count", 64'(mosi_q.size()), 64'd128);
    check("R5 byte7", 64'(qbyte(7)), 64'h08);
    check("R5 byte8", 64'(qbyte(8)), 64'h11);
    check("R5 byte15", 64'(qbyte(15)), 64'h18);
    rd(4'd8, r); check("R5 underrun flag", r, 64'h0201_0000_0000_0000);
    wr(4'd8, 64'd0);
    rd(4'd8, r); check("R13 status write clears", r, IDLE_ST);

    // R8: double write
    wr(4'd5, 64'hCAFE_0000_0000_0000);
    wr(4'd5, 64'h1234_0000_0000_0000);
    rd(4'd8, r); check("R8 overrun flag", r, 64'h0C01_0000_0000_0000);
    rd(4'd5, r); check("R8 word kept", r, 64'hCAFE_0000_0000_0000);
    wr(4'd8, 64'd0);

    // R10: copy re-arms the word
    start_run({8'h11, 8'h31, 8'hC0, 8'h31, 8'h10, 24'h0});
    wait_state(8'h01, "R10 copy idle");
    check("R10 copy bits", 64'(mosi_q.size()), 64'd16);
    check("R10 copy byte1", 64'(qbyte(1)), 64'hCA);
    rd(4'd8, r); check("R10 copy status", r, IDLE_ST);

    // R10: branch skips slot 2
    wr(4'd5, 64'h9900_0000_0000_0000);
    start_run({8'h11, 8'hE3, 8'h32, 8'h31, 8'h10, 24'h0});
    wait_state(8'h01, "R10 branch idle");
    check("R10 branch bits", 64'(mosi_q.size()), 64'd8);
    check("R10 branch byte", 64'(qbyte(0)), 64'h99);

    // R9: underrun and overrun on receive
    rd(4'd6, r);
    rd(4'd8, r); check("R9 underrun", r, 64'h2001_0000_0000_0000);
    wr(4'd8, 64'd0);
    wr(4'd5, 64'h7700_0000_0000_0000);
    start_run({8'h11, 8'h31, 8'h41, 8'h10, 32'h0});
    miso_pat = {8'h00, 8'h3C, 48'h0};
    wait_state(8'h01, "R9 first rx");
    wr(4'd5, 64'h7700_0000_0000_0000);
    start_run({8'h11, 8'h31, 8'h41, 8'h10, 32'h0});
    miso_pat = {8'h00, 8'hC3, 48'h0};
    wait_state(8'h01, "R9 second rx");
    rd(4'd8, r); check("R9 overrun", r, 64'hC001_0000_0000_0000);
    rd(4'd6, r); check("R9 old word kept", r, 64'h3C);
    wr(4'd8, 64'd0);

    // R11: illegal opcodes
    start_run({8'h11, 8'h77, 48'h0});
    wait_state(8'h01, "R11 idle");
    rd(4'd8, r); check("R11 undefined op", r, 64'h0001_0000_0000_1000);
    check("R11 cs released", 64'(cs_n), 64'hF);
    wr(4'd8, 64'd0);
    start_run({8'h11, 8'h41, 8'h10, 40'h0});
    wait_state(8'h01, "R11 idle 2");
    rd(4'd8, r); check("R11 shift-in without send", r, 64'h0001_0000_0000_1000);
    check("R11 no bits", 64'(mosi_q.size()), 64'd0);
    wr(4'd8, 64'd0);

    // R2: runs through slot 7 and stops
    start_run({8'h10, 8'h10, 8'h10, 8'h10, 8'h10, 8'h10, 8'h10, 8'h14});
    wait_state(8'h01, "R2 slot7 idle");
    check("R2 slot7 executed", 64'(cs_n), 64'h7);
    rd(4'd8, r); check("R2 no error", r, IDLE_ST);

    // R12 R13: write during run, then soft reset
    start_run({8'h11, 8'h31, 8'h10, 40'h0});
    wait_state(8'h04, "R12 waiting");
    wr(4'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(4'd7, r); check("R12 program kept", r, {8'h11, 8'h31, 8'h10, 40'h0});
    rd(4'd8, r); check("R12 state", r, 64'h0204_0000_0000_0000);
    wr(4'd3, (64'd1 << 36) | (64'd1 << 38));
    wr(4'd3, (64'd1 << 37) | (64'd1 << 39));
    exp_div = 0;
    repeat (2) @(negedge clk);
    rd(4'd8, r); check("R13 soft reset status", r, IDLE_ST);
    check("R13 soft reset cs", 64'(cs_n), 64'hF);

    // R7: divider 3
    wr(4'd3, 64'd3 << 52); exp_div = 3;
    wr(4'd5, 64'h8100_0000_0000_0000);
    start_run({8'h11, 8'h31, 8'h10, 40'h0});
    wait_state(8'h01, "R7 idle");
    check("R7 period div3", 64'(period), 64'd8);
    check("R7 byte", 64'(qbyte(0)), 64'h81);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule